// File: doc/BRIEF.md
# LCD Frame and Common-Line Timing Generator

This block produces the frame and common-line timing for a multiplexed segment LCD driver. It counts a clock-enable strobe taken from the LCD clock and divides it by a frame ratio. The duty setting and the frame-rate setting choose that ratio together. Each frame is split into equal common-line slots, one slot per active common line. The block outputs the index of the common line being driven and a one-cycle pulse at the start of each frame. It also outputs a square-wave frame signal that inverts the drive polarity on alternate frames, and a flag that sets four shared pins to common or segment use.

The duty and rate inputs are sampled only at a frame boundary. A change made in the middle of a frame therefore never produces a short or mixed frame. The analog drive levels, the segment data storage, the choice of clock source and the pin multiplexing sit outside this block.

Top module: `lcdt_frame_gen`

## Requirements
- R1: After a synchronous reset, `com_idx` is 0, `frame_start` is 0, `frame_out` is 0 and `shared_as_com` is 1. The active setting is 1/8 duty with rate code 1, so the first frame lasts 512 strobes.
- R2: The duty codes are 0 static, 1 one-half, 2 one-third, 3 one-quarter and 4 one-eighth. For every duty other than one-third, rate codes 0, 1, 2 and 3 give frames of 256, 512, 680 and 1024 strobes.
- R3: At one-third duty (code 2), rate codes 0, 1, 2 and 3 give frames of 252, 504, 681 and 1008 strobes.
- R4: The number of active common lines N is 1, 2, 3, 4 or 8 for duty codes 0, 1, 2, 3 and 4. `com_idx` steps upward from 0 to N-1. It holds each value for (frame ratio)/N strobes.
- R5: `frame_start` is high for exactly one clock. That clock follows the strobe that ends the last slot of a frame, when `com_idx` returns to 0.
- R6: An internal frame signal inverts at each frame start. `frame_out` equals that signal while `fout_en` is 1 and is 0 while `fout_en` is 0.
- R7: `shared_as_com` is 1 only while the active duty is one-eighth. Otherwise the four shared pins serve as segment lines.
- R8: Duty codes 5, 6 and 7 behave exactly as one-eighth duty.
- R9: A change on `duty_sel` or `rate_sel` is taken in only at the strobe that ends a frame. The next frame then starts from slot 0 with the new setting.
- R10: In a clock where `lclk_en` is 0, the counters, `com_idx` and the frame signal do not change, and no `frame_start` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lclk_en | input | 1 | One-clock strobe at the LCD clock rate |
| duty_sel | input | 3 | Requested duty code |
| rate_sel | input | 2 | Requested frame-rate code |
| fout_en | input | 1 | Enables the external frame signal |
| com_idx | output | 3 | Index of the active common line |
| frame_start | output | 1 | One-clock pulse at each frame start |
| frame_out | output | 1 | Gated polarity square wave |
| shared_as_com | output | 1 | 1: shared pins act as commons 4 to 7 |

## Verification
The assertions assume that strobes are at least one clock apart in their effect. They also assume that every frame lasts many strobes, so two frame boundaries never fall in adjacent clocks. Because the shortest legal slot is 32 strobes, no choice of settings can break this. The stimulus draws duty codes from the full 3-bit range, reserved codes included. It drives the strobe with random gaps and changes the settings at random points inside frames. Every setting it drives is therefore legal or defined, and the assumption always holds.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int COM_W   = 3;
    localparam int CNT_W   = 10;
    localparam int RATIO_W = CNT_W + 1;

    typedef enum logic [2:0] {
        DUTY_STATIC  = 3'd0,
        DUTY_HALF    = 3'd1,
        DUTY_THIRD   = 3'd2,
        DUTY_QUARTER = 3'd3,
        DUTY_EIGHTH  = 3'd4
    } duty_e;

    typedef struct packed {
        duty_e      duty;
        logic [1:0] rate;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{duty: DUTY_EIGHTH, rate: 2'd1};

    function automatic duty_e norm_duty(input logic [2:0] code);
        if (code > 3'd4) return DUTY_EIGHTH;
        return duty_e'(code);
    endfunction

    function automatic logic [COM_W:0] com_count(input duty_e d);
        case (d)
            DUTY_STATIC:  return 4'd1;
            DUTY_HALF:    return 4'd2;
            DUTY_THIRD:   return 4'd3;
            DUTY_QUARTER: return 4'd4;
            default:      return 4'd8;
        endcase
    endfunction

    function automatic logic [RATIO_W-1:0] frame_ratio(input cfg_t c);
        logic [RATIO_W-1:0] r;
        if (c.duty == DUTY_THIRD) begin
            case (c.rate)
                2'd0:    r = 11'd252;
                2'd1:    r = 11'd504;
                2'd2:    r = 11'd681;
                default: r = 11'd1008;
            endcase
        end else begin
            case (c.rate)
                2'd0:    r = 11'd256;
                2'd1:    r = 11'd512;
                2'd2:    r = 11'd680;
                default: r = 11'd1024;
            endcase
        end
        return r;
    endfunction

    function automatic logic [RATIO_W-1:0] slot_len(input cfg_t c);
        return frame_ratio(c) / RATIO_W'(com_count(c.duty));
    endfunction

endpackage

// File: rtl/lcdt_cfg_reg.sv
module lcdt_cfg_reg
    import lcdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wrap,
    input  logic [2:0] duty_in,
    input  logic [1:0] rate_in,
    output cfg_t       cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (wrap) begin
            cfg_q.duty <= norm_duty(duty_in);
            cfg_q.rate <= rate_in;
        end
    end

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cfg_q));

endmodule

// File: rtl/lcdt_slot_ctr.sv
module lcdt_slot_ctr
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  cfg_t             cfg,
    output logic [COM_W-1:0] com_idx,
    output logic             wrap
);
    logic [CNT_W-1:0]   cnt_q;
    logic [RATIO_W-1:0] slot_q;
    logic [COM_W:0]     ncom;
    logic               slot_end;
    logic               last_com;

    assign slot_q   = slot_len(cfg);
    assign ncom     = com_count(cfg.duty);
    assign slot_end = ({1'b0, cnt_q} == slot_q - RATIO_W'(1));
    assign last_com = ({1'b0, com_idx} == ncom - (COM_W+1)'(1));
    assign wrap     = tick && slot_end && last_com;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            com_idx <= '0;
        end else if (tick) begin
            if (slot_end) begin
                cnt_q   <= '0;
                com_idx <= last_com ? '0 : com_idx + COM_W'(1);
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assert_com_range_R4: assert property (@(posedge clk) disable iff (rst)
        {1'b0, com_idx} < ncom);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(com_idx) && $stable(cnt_q)));

endmodule

// File: rtl/lcdt_frame_out.sv
module lcdt_frame_out (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic fout_en,
    output logic frame_start,
    output logic frame_out
);
    logic fsig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start <= 1'b0;
            fsig_q      <= 1'b0;
        end else begin
            frame_start <= wrap;
            if (wrap) fsig_q <= ~fsig_q;
        end
    end

    assign frame_out = fsig_q & fout_en;

    assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    assert_polarity_flip_R6: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (fsig_q != $past(fsig_q)));

endmodule

// File: rtl/lcdt_frame_gen.sv
module lcdt_frame_gen
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lclk_en,
    input  logic [2:0]       duty_sel,
    input  logic [1:0]       rate_sel,
    input  logic             fout_en,
    output logic [COM_W-1:0] com_idx,
    output logic             frame_start,
    output logic             frame_out,
    output logic             shared_as_com
);
    cfg_t cfg;
    logic wrap;

    lcdt_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .duty_in (duty_sel),
        .rate_in (rate_sel),
        .cfg_q   (cfg)
    );

    lcdt_slot_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .tick    (lclk_en),
        .cfg     (cfg),
        .com_idx (com_idx),
        .wrap    (wrap)
    );

    lcdt_frame_out u_fout (
        .clk         (clk),
        .rst         (rst),
        .wrap        (wrap),
        .fout_en     (fout_en),
        .frame_start (frame_start),
        .frame_out   (frame_out)
    );

    assign shared_as_com = (cfg.duty == DUTY_EIGHTH);

    assert_shared_only_eighth_R7: assert property (@(posedge clk) disable iff (rst)
        shared_as_com |-> (com_count(cfg.duty) == 4'd8));

endmodule

// File: tb/lcdt_frame_gen_bench.sv
module lcdt_frame_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lclk_en = 1'b0;
    logic [2:0] duty_sel = 3'd4;
    logic [1:0] rate_sel = 2'd1;
    logic       fout_en = 1'b0;
    logic [2:0] com_idx;
    logic       frame_start;
    logic       frame_out;
    logic       shared_as_com;

    lcdt_frame_gen u_lcdt_frame_gen (
        .clk           (clk),
        .rst           (rst),
        .lclk_en       (lclk_en),
        .duty_sel      (duty_sel),
        .rate_sel      (rate_sel),
        .fout_en       (fout_en),
        .com_idx       (com_idx),
        .frame_start   (frame_start),
        .frame_out     (frame_out),
        .shared_as_com (shared_as_com)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int m_duty = 4, m_rate = 1, m_cnt = 0, m_com = 0, m_fs = 0, m_fsig = 0;
    int last_len = 512, last_duty = 4, last_raw = 4;
    int sc = 0;
    bit first_frame = 1;

    function automatic int exp_ratio(int d, int r);
        int t3[4] = '{252, 504, 681, 1008};
        int tn[4] = '{256, 512, 680, 1024};
        return (d == 2) ? t3[r] : tn[r];
    endfunction

    function automatic int exp_ncom(int d);
        case (d)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            default: return 8;
        endcase
    endfunction

    task automatic chk(string tag, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic tick(bit en);
        @(negedge clk);
        chk("R4 com_idx", int'(com_idx), m_com);
        chk("R5 frame_start", int'(frame_start), m_fs);
        chk("R6 frame_out", int'(frame_out), (m_fsig != 0 && fout_en) ? 1 : 0);
        chk("R7 shared_as_com", int'(shared_as_com), (m_duty == 4) ? 1 : 0);
        if (frame_start && !rst) begin
            if (first_frame)         chk("R1 first frame length", sc, 512);
            else if (last_raw > 4)   chk("R8 reserved frame length", sc, last_len);
            else if (last_duty == 2) chk("R3 third-duty frame length", sc, last_len);
            else                     chk("R2 frame length", sc, last_len);
            first_frame = 0;
            sc = 0;
        end
        lclk_en = en;
        m_fs = 0;
        if (!rst && en) begin
            sc++;
            if (m_cnt == exp_ratio(m_duty, m_rate) / exp_ncom(m_duty) - 1) begin
                m_cnt = 0;
                if (m_com == exp_ncom(m_duty) - 1) begin
                    last_len  = exp_ratio(m_duty, m_rate);
                    last_duty = m_duty;
                    m_com  = 0;
                    m_fs   = 1;
                    m_fsig = 1 - m_fsig;
                    last_raw = int'(duty_sel);
                    m_duty = (duty_sel > 3'd4) ? 4 : int'(duty_sel);
                    m_rate = int'(rate_sel);
                end else begin
                    m_com++;
                end
            end else begin
                m_cnt++;
            end
        end
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hold_com;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) tick(0);
        rst = 1'b0;
        tick(0);
        chk("R1 reset com_idx", int'(com_idx), 0);
        chk("R1 reset frame_start", int'(frame_start), 0);
        chk("R1 reset frame_out", int'(frame_out), 0);
        chk("R1 reset shared_as_com", int'(shared_as_com), 1);

        fout_en = 1'b1;
        for (int i = 0; i < 100; i++) tick(1);
        duty_sel = 3'd0;
        rate_sel = 2'd0;
        for (int i = 0; i < 30; i++) tick(1);
        chk("R9 setting held mid-frame", int'(shared_as_com), 1);
        hold_com = int'(com_idx);
        for (int i = 0; i < 20; i++) tick(0);
        chk("R10 idle com_idx", int'(com_idx), hold_com);
        chk("R10 idle frame_start", int'(frame_start), 0);
        for (int i = 0; i < 600; i++) tick(1);

        duty_sel = 3'd2;
        rate_sel = 2'd2;
        for (int i = 0; i < 1500; i++) tick(1);
        duty_sel = 3'd6;
        rate_sel = 2'd0;
        for (int i = 0; i < 1200; i++) tick(1);

        for (int i = 0; i < 70000; i++) begin
            if ($urandom % 700 == 0) begin
                duty_sel = 3'($urandom % 8);
                rate_sel = 2'($urandom % 4);
            end
            if ($urandom % 64 == 0) fout_en = ~fout_en;
            tick(($urandom % 4) != 0);
        end
        tick(0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule